// File: doc/BRIEF.md
# Execute Redirect Selector

This block sits at the end of the execute stage of an out-of-order core that runs several hardware threads. Each cycle it looks at one group of executed results, up to `LANES` of them, each tagged with its thread. From the group it raises at most one squash request per thread towards the commit stage.

Three kinds of event can trigger a squash: a branch that resolved against its prediction, a memory-ordering violation reported by the load/store queue, and a load that was refused by memory and has not yet been handled. Each kind fills the redirect fields in its own way. The block also keeps two running counts of branch mispredictions, split by the direction that was wrongly predicted.

The result stream flows in only. A group is offered with `grp_valid`, and the block takes every group offered, so it never applies back-pressure and has no ready output. The per-thread squash requests leave as one-cycle registered strobes with no ready input, because the commit stage always accepts them. The memory side reports that a blocked condition has ended through the plain control pins `blk_rearm`.

Top module: `exe_redirect_sel`

## Requirements
- R1: While reset is asserted (rst_n low), all squash strobes, redirect fields, flags, handled bits and both counters are zero.
- R2: Each thread gets at most one squash per group. The winner is the lowest-numbered lane whose thread matches and which carries a qualifying event, whatever kind a later lane carries. The request is registered and appears on the outputs the cycle after the group is presented. Each thread's outputs are independent of the other threads' lanes.
- R3: Within one instruction the priority is branch mispredict, then memory-order violation, then unhandled blocked load.
- R4: A branch squash drives the sequence number, a target equal to the next PC and a mispredict PC equal to the instruction's PC. It sets sq_mispred to 1 and sq_incl to 0.
- R5: On a branch squash, sq_taken is 1 exactly when the next PC differs from PC + INST_BYTES (default 4). On every other kind, sq_taken is 0.
- R6: A memory-order squash drives the sequence number and a target equal to the next PC. It sets sq_incl, sq_mispred and sq_taken to 0, and drives sq_mispc to 0.
- R7: A blocked-load squash drives the sequence number and a target equal to the instruction's own PC. It sets sq_incl to 1, drives sq_mispc to 0, and sets that thread's blk_handled bit on the same edge.
- R8: While blk_handled[t] is 1, blocked-load flags on lanes of thread t are ignored. This uses the registered bit, so a blk_rearm[t] pulse in the same cycle does not re-arm that cycle. blk_rearm[t] clears the bit at the clock edge, but a blocked-load squash on that same edge sets it again.
- R9: cnt_ntk_wrong counts branch squashes with sq_taken 1, and cnt_tkn_wrong counts those with sq_taken 0. Each counts one per winning thread per group, so several can be added in one cycle.
- R10: Lanes are ignored when grp_valid is 0 or when their own ln_valid bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_valid | input | 1 | A result group is presented this cycle |
| ln_valid | input | LANES | Per-lane result present |
| ln_tid | input | LANES*TID_W | Per-lane thread number |
| ln_seq | input | LANES*SEQ_W | Per-lane sequence number |
| ln_pc | input | LANES*PC_W | Per-lane instruction PC |
| ln_npc | input | LANES*PC_W | Per-lane resolved next PC |
| ln_mispred | input | LANES | Lane resolved a branch against its prediction |
| ln_memviol | input | LANES | Lane reports a memory-ordering violation |
| ln_ldblk | input | LANES | Lane is a load refused by memory |
| blk_rearm | input | THREADS | Per-thread end of a blocked-memory episode |
| sq_valid | output | THREADS | Per-thread squash strobe |
| sq_seq | output | THREADS*SEQ_W | Squash sequence number |
| sq_target | output | THREADS*PC_W | Redirect PC |
| sq_mispc | output | THREADS*PC_W | PC of the mispredicted branch, zero otherwise |
| sq_incl | output | THREADS | Squash includes the instruction itself |
| sq_mispred | output | THREADS | Squash is a branch mispredict |
| sq_taken | output | THREADS | Mispredicted branch was actually taken |
| blk_handled | output | THREADS | Blocked condition already answered for the thread |
| cnt_tkn_wrong | output | CNT_W | Predicted-taken-but-wrong count |
| cnt_ntk_wrong | output | CNT_W | Predicted-not-taken-but-wrong count |

## Verification
The table walk drives groups that contrast the selection rules. Some groups stack all three flags on one instruction, which isolates the in-instruction priority. Others put a low-priority event in an early lane and a branch in a later lane, which separates lane order from kind priority. Mixed-thread groups show that one thread's winner leaves the other untouched, and invalid lanes that carry flags show that only valid results count. Directed sequences repeat blocked loads with and without a rearm, and place the rearm on the same cycle as a blocked load, which tells the registered handled bit from a combinational one. Next PCs of exactly PC+4, PC+8 and PC itself probe the taken decision at its boundary.

// File: rtl/exe_redirect_pkg.sv
package exe_redirect_pkg;
  typedef enum logic [1:0] {
    SQK_NONE   = 2'd0,
    SQK_BRANCH = 2'd1,
    SQK_MEMORD = 2'd2,
    SQK_LDBLK  = 2'd3
  } sq_kind_e;
endpackage

// File: rtl/exe_redirect_lane.sv
// Classifies one executed result into the squash kind it would request.
module exe_redirect_lane
  import exe_redirect_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int INST_BYTES = 4,
  parameter int THREADS    = 2,
  parameter int TID_W      = 1
) (
  input  logic               valid,
  input  logic [TID_W-1:0]   tid,
  input  logic [PC_W-1:0]    pc,
  input  logic [PC_W-1:0]    npc,
  input  logic               mispred,
  input  logic               memviol,
  input  logic               ldblk,
  input  logic [THREADS-1:0] handled,
  output sq_kind_e           kind,
  output logic               taken
);
  logic ld_armed;

  always_comb begin
    ld_armed = 1'b0;
    for (int t = 0; t < THREADS; t++) begin
      if (tid == TID_W'(t)) ld_armed = ~handled[t];
    end
    taken = (npc != (pc + PC_W'(INST_BYTES)));
    kind  = SQK_NONE;
    if (valid) begin
      if (mispred)                kind = SQK_BRANCH;
      else if (memviol)           kind = SQK_MEMORD;
      else if (ldblk && ld_armed) kind = SQK_LDBLK;
    end
  end
endmodule

// File: rtl/exe_redirect_pick.sv
// For one thread, selects the first qualifying lane and forms its redirect.
module exe_redirect_pick
  import exe_redirect_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int TID_W    = 1,
  parameter int SEQ_W    = 16,
  parameter int PC_W     = 32,
  parameter int THIS_TID = 0
) (
  input  logic [LANES-1:0][TID_W-1:0] tid,
  input  sq_kind_e                    kind [LANES],
  input  logic [LANES-1:0]            taken,
  input  logic [LANES-1:0][SEQ_W-1:0] seq,
  input  logic [LANES-1:0][PC_W-1:0]  pc,
  input  logic [LANES-1:0][PC_W-1:0]  npc,
  output logic                        hit,
  output sq_kind_e                    win_kind,
  output logic [SEQ_W-1:0]            win_seq,
  output logic [PC_W-1:0]             win_target,
  output logic [PC_W-1:0]             win_mispc,
  output logic                        win_incl,
  output logic                        win_mispred,
  output logic                        win_taken
);
  always_comb begin
    hit         = 1'b0;
    win_kind    = SQK_NONE;
    win_seq     = '0;
    win_target  = '0;
    win_mispc   = '0;
    win_incl    = 1'b0;
    win_mispred = 1'b0;
    win_taken   = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (!hit && kind[i] != SQK_NONE && tid[i] == TID_W'(THIS_TID)) begin
        hit      = 1'b1;
        win_kind = kind[i];
        win_seq  = seq[i];
        case (kind[i])
          SQK_BRANCH: begin
            win_target  = npc[i];
            win_mispc   = pc[i];
            win_mispred = 1'b1;
            win_taken   = taken[i];
          end
          SQK_MEMORD: win_target = npc[i];
          SQK_LDBLK: begin
            win_target = pc[i];
            win_incl   = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/exe_redirect_ctr.sv
// Misprediction event counters, one increment per winning thread.
module exe_redirect_ctr #(
  parameter int THREADS = 2,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [THREADS-1:0] bump_tk,
  input  logic [THREADS-1:0] bump_nt,
  output logic [CNT_W-1:0]   tkn_wrong,
  output logic [CNT_W-1:0]   ntk_wrong
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tkn_wrong <= '0;
      ntk_wrong <= '0;
    end else begin
      tkn_wrong <= tkn_wrong + CNT_W'($countones(bump_tk));
      ntk_wrong <= ntk_wrong + CNT_W'($countones(bump_nt));
    end
  end
endmodule

// File: rtl/exe_redirect_sel.sv
module exe_redirect_sel
  import exe_redirect_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int THREADS    = 2,
  parameter int SEQ_W      = 16,
  parameter int PC_W       = 32,
  parameter int INST_BYTES = 4,
  parameter int CNT_W      = 16,
  localparam int TID_W     = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     grp_valid,
  input  logic [LANES-1:0]         ln_valid,
  input  logic [LANES*TID_W-1:0]   ln_tid,
  input  logic [LANES*SEQ_W-1:0]   ln_seq,
  input  logic [LANES*PC_W-1:0]    ln_pc,
  input  logic [LANES*PC_W-1:0]    ln_npc,
  input  logic [LANES-1:0]         ln_mispred,
  input  logic [LANES-1:0]         ln_memviol,
  input  logic [LANES-1:0]         ln_ldblk,
  input  logic [THREADS-1:0]       blk_rearm,
  output logic [THREADS-1:0]       sq_valid,
  output logic [THREADS*SEQ_W-1:0] sq_seq,
  output logic [THREADS*PC_W-1:0]  sq_target,
  output logic [THREADS*PC_W-1:0]  sq_mispc,
  output logic [THREADS-1:0]       sq_incl,
  output logic [THREADS-1:0]       sq_mispred,
  output logic [THREADS-1:0]       sq_taken,
  output logic [THREADS-1:0]       blk_handled,
  output logic [CNT_W-1:0]         cnt_tkn_wrong,
  output logic [CNT_W-1:0]         cnt_ntk_wrong
);
  logic [LANES-1:0][TID_W-1:0] lane_tid;
  logic [LANES-1:0][SEQ_W-1:0] lane_seq;
  logic [LANES-1:0][PC_W-1:0]  lane_pc;
  logic [LANES-1:0][PC_W-1:0]  lane_npc;
  logic [LANES-1:0]            lane_taken;
  sq_kind_e                    lane_kind [LANES];

  assign lane_tid = ln_tid;
  assign lane_seq = ln_seq;
  assign lane_pc  = ln_pc;
  assign lane_npc = ln_npc;

  logic [THREADS-1:0]            r_handled;
  logic [THREADS-1:0]            p_hit, p_incl, p_mispred, p_taken;
  sq_kind_e                      p_kind [THREADS];
  logic [THREADS-1:0][SEQ_W-1:0] p_seq;
  logic [THREADS-1:0][PC_W-1:0]  p_target, p_mispc;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    exe_redirect_lane #(
      .PC_W(PC_W), .INST_BYTES(INST_BYTES), .THREADS(THREADS), .TID_W(TID_W)
    ) u_lane (
      .valid   (grp_valid & ln_valid[i]),
      .tid     (lane_tid[i]),
      .pc      (lane_pc[i]),
      .npc     (lane_npc[i]),
      .mispred (ln_mispred[i]),
      .memviol (ln_memviol[i]),
      .ldblk   (ln_ldblk[i]),
      .handled (r_handled),
      .kind    (lane_kind[i]),
      .taken   (lane_taken[i])
    );
  end

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    exe_redirect_pick #(
      .LANES(LANES), .TID_W(TID_W), .SEQ_W(SEQ_W), .PC_W(PC_W), .THIS_TID(t)
    ) u_pick (
      .tid         (lane_tid),
      .kind        (lane_kind),
      .taken       (lane_taken),
      .seq         (lane_seq),
      .pc          (lane_pc),
      .npc         (lane_npc),
      .hit         (p_hit[t]),
      .win_kind    (p_kind[t]),
      .win_seq     (p_seq[t]),
      .win_target  (p_target[t]),
      .win_mispc   (p_mispc[t]),
      .win_incl    (p_incl[t]),
      .win_mispred (p_mispred[t]),
      .win_taken   (p_taken[t])
    );
  end

  logic [THREADS-1:0]            r_valid, r_incl, r_mispred, r_taken;
  logic [THREADS-1:0][SEQ_W-1:0] r_seq;
  logic [THREADS-1:0][PC_W-1:0]  r_target, r_mispc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_valid   <= '0;
      r_incl    <= '0;
      r_mispred <= '0;
      r_taken   <= '0;
      r_seq     <= '0;
      r_target  <= '0;
      r_mispc   <= '0;
      r_handled <= '0;
    end else begin
      for (int t = 0; t < THREADS; t++) begin
        r_valid[t]   <= p_hit[t];
        r_incl[t]    <= p_incl[t];
        r_mispred[t] <= p_mispred[t];
        r_taken[t]   <= p_taken[t];
        r_seq[t]     <= p_seq[t];
        r_target[t]  <= p_target[t];
        r_mispc[t]   <= p_mispc[t];
        r_handled[t] <= (r_handled[t] & ~blk_rearm[t]) |
                        (p_hit[t] && p_kind[t] == SQK_LDBLK);
      end
    end
  end

  exe_redirect_ctr #(.THREADS(THREADS), .CNT_W(CNT_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .bump_tk   (p_mispred & ~p_taken),
    .bump_nt   (p_mispred & p_taken),
    .tkn_wrong (cnt_tkn_wrong),
    .ntk_wrong (cnt_ntk_wrong)
  );

  assign sq_valid    = r_valid;
  assign sq_seq      = r_seq;
  assign sq_target   = r_target;
  assign sq_mispc    = r_mispc;
  assign sq_incl     = r_incl;
  assign sq_mispred  = r_mispred;
  assign sq_taken    = r_taken;
  assign blk_handled = r_handled;
endmodule

// File: rtl/exe_redirect_sel_chk.sv
module exe_redirect_sel_chk #(
  parameter int THREADS = 2,
  parameter int PC_W    = 32,
  parameter int CNT_W   = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    grp_valid,
  input logic [THREADS-1:0]      blk_rearm,
  input logic [THREADS-1:0]      sq_valid,
  input logic [THREADS*PC_W-1:0] sq_mispc,
  input logic [THREADS-1:0]      sq_incl,
  input logic [THREADS-1:0]      sq_mispred,
  input logic [THREADS-1:0]      sq_taken,
  input logic [THREADS-1:0]      blk_handled,
  input logic [CNT_W-1:0]        cnt_tkn_wrong,
  input logic [CNT_W-1:0]        cnt_ntk_wrong
);
  a_r10_idle_group_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_valid |=> sq_valid == '0);

  a_r9_counter_step: assert property (@(posedge clk) disable iff (!rst_n)
    CNT_W'((cnt_tkn_wrong - $past(cnt_tkn_wrong)) + (cnt_ntk_wrong - $past(cnt_ntk_wrong)))
      == CNT_W'($countones(sq_mispred)));

  for (genvar t = 0; t < THREADS; t++) begin : g_t
    a_r4_branch_excludes_self: assert property (@(posedge clk) disable iff (!rst_n)
      sq_mispred[t] |-> sq_valid[t] && !sq_incl[t]);

    a_r5_taken_only_on_branch: assert property (@(posedge clk) disable iff (!rst_n)
      sq_taken[t] |-> sq_mispred[t]);

    a_r7_include_marks_handled: assert property (@(posedge clk) disable iff (!rst_n)
      sq_incl[t] |-> sq_valid[t] && blk_handled[t] && sq_mispc[t*PC_W +: PC_W] == '0);

    a_r8_handled_holds: assert property (@(posedge clk) disable iff (!rst_n)
      blk_handled[t] && !blk_rearm[t] |=> blk_handled[t]);

    a_r8_rearm_clears: assert property (@(posedge clk) disable iff (!rst_n)
      blk_handled[t] && blk_rearm[t] |=> !blk_handled[t] || sq_incl[t]);
  end
endmodule

bind exe_redirect_sel exe_redirect_sel_chk #(
  .THREADS(THREADS), .PC_W(PC_W), .CNT_W(CNT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .grp_valid     (grp_valid),
  .blk_rearm     (blk_rearm),
  .sq_valid      (sq_valid),
  .sq_mispc      (sq_mispc),
  .sq_incl       (sq_incl),
  .sq_mispred    (sq_mispred),
  .sq_taken      (sq_taken),
  .blk_handled   (blk_handled),
  .cnt_tkn_wrong (cnt_tkn_wrong),
  .cnt_ntk_wrong (cnt_ntk_wrong)
);

// File: tb/exe_redirect_sel_bench.sv
module exe_redirect_sel_bench;
  localparam int LANES   = 4;
  localparam int THREADS = 2;
  localparam int SEQ_W   = 16;
  localparam int PC_W    = 32;
  localparam int CNT_W   = 16;
  localparam int TID_W   = 1;
  localparam int NV      = 8;

  // lane word: {valid, tid, mispred, memviol, ldblk, taken}
  function automatic logic [5:0] L(int v, int t, int mp, int mo, int lb, int tk);
    return {v[0], t[0], mp[0], mo[0], lb[0], tk[0]};
  endfunction
  // expectation: {kind(0 none,1 branch,2 memorder,3 blocked), lane}
  function automatic logic [3:0] E(int k, int ln);
    return {k[1:0], ln[1:0]};
  endfunction

  // {lane3, lane2, lane1, lane0, expect thread1, expect thread0}
  localparam logic [31:0] VECS [NV] = '{
    {L(0,0,0,0,0,0), L(0,0,0,0,0,0), L(0,0,0,0,0,0), L(0,0,0,0,0,0), E(0,0), E(0,0)},
    {L(0,0,0,0,0,0), L(0,0,0,0,0,0), L(0,0,0,0,0,0), L(1,0,1,0,0,1), E(0,0), E(1,0)},
    {L(1,1,1,0,0,0), L(1,0,0,0,1,0), L(1,1,0,1,0,0), L(1,0,0,0,0,0), E(2,1), E(3,2)},
    {L(0,0,0,0,0,0), L(0,0,0,0,0,0), L(0,0,0,0,0,0), L(1,1,1,1,1,0), E(1,0), E(0,0)},
    {L(0,0,0,0,0,0), L(0,0,0,0,0,0), L(0,0,0,0,0,0), L(1,0,0,1,1,0), E(0,0), E(2,0)},
    {L(0,0,0,0,0,0), L(1,0,1,0,0,1), L(1,0,0,0,1,0), L(1,0,0,0,0,0), E(0,0), E(3,1)},
    {L(0,0,0,0,0,0), L(1,0,1,0,0,0), L(1,1,1,0,0,1), L(0,0,1,0,0,0), E(1,1), E(1,2)},
    {L(1,0,0,1,0,0), L(0,0,0,0,0,0), L(0,0,0,0,0,0), L(0,0,0,0,0,0), E(0,0), E(2,3)}
  };

  function automatic string vreq(int vi);
    case (vi)
      3, 4:    return "R3";
      5, 7:    return "R2";
      6:       return "R10";
      default: return "R2";
    endcase
  endfunction

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  logic                        grp_valid;
  logic [LANES-1:0]            b_valid, b_mp, b_mo, b_lb;
  logic [LANES-1:0][TID_W-1:0] b_tid;
  logic [LANES-1:0][SEQ_W-1:0] b_seq;
  logic [LANES-1:0][PC_W-1:0]  b_pc, b_npc;
  logic [THREADS-1:0]          rearm;

  logic [THREADS-1:0]       sq_valid, sq_incl, sq_mispred, sq_taken, blk_handled;
  logic [THREADS*SEQ_W-1:0] sq_seq;
  logic [THREADS*PC_W-1:0]  sq_target, sq_mispc;
  logic [CNT_W-1:0]         cnt_tkn_wrong, cnt_ntk_wrong;

  exe_redirect_sel #(
    .LANES(LANES), .THREADS(THREADS), .SEQ_W(SEQ_W), .PC_W(PC_W),
    .INST_BYTES(4), .CNT_W(CNT_W)
  ) u_exe_redirect_sel (
    .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid),
    .ln_valid(b_valid), .ln_tid(b_tid), .ln_seq(b_seq), .ln_pc(b_pc), .ln_npc(b_npc),
    .ln_mispred(b_mp), .ln_memviol(b_mo), .ln_ldblk(b_lb), .blk_rearm(rearm),
    .sq_valid(sq_valid), .sq_seq(sq_seq), .sq_target(sq_target), .sq_mispc(sq_mispc),
    .sq_incl(sq_incl), .sq_mispred(sq_mispred), .sq_taken(sq_taken),
    .blk_handled(blk_handled), .cnt_tkn_wrong(cnt_tkn_wrong), .cnt_ntk_wrong(cnt_ntk_wrong)
  );

  int n_chk = 0;
  int n_err = 0;
  int e_tkn = 0;
  int e_ntk = 0;
  bit done  = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_inputs();
    grp_valid = 1'b0;
    b_valid = '0; b_mp = '0; b_mo = '0; b_lb = '0;
    b_tid = '0; b_seq = '0; b_pc = '0; b_npc = '0;
    rearm = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_rearm();
    clear_inputs();
    rearm = '1;
    step();
    rearm = '0;
  endtask

  task automatic set_lane(int i, int tid, int seq, logic [PC_W-1:0] pc,
                          logic [PC_W-1:0] npc, int mp, int mo, int lb);
    b_valid[i] = 1'b1;
    b_tid[i]   = TID_W'(tid);
    b_seq[i]   = SEQ_W'(seq);
    b_pc[i]    = pc;
    b_npc[i]   = npc;
    b_mp[i]    = mp[0];
    b_mo[i]    = mo[0];
    b_lb[i]    = lb[0];
  endtask

  // Expected thread outputs from the lane data still held on the bench side.
  task automatic exp_thread(int t, int kind, int lane, string req);
    logic [84:0] ev, av;
    logic [SEQ_W-1:0] es;
    logic [PC_W-1:0] et, em;
    logic ei, ep, ek;
    es = '0; et = '0; em = '0; ei = 1'b0; ep = 1'b0; ek = 1'b0;
    if (kind != 0) begin
      es = b_seq[lane];
      et = (kind == 3) ? b_pc[lane] : b_npc[lane];
    end
    if (kind == 1) begin
      em = b_pc[lane];
      ep = 1'b1;
      ek = (b_npc[lane] != b_pc[lane] + 32'd4);
      if (ek) e_ntk++; else e_tkn++;
    end
    if (kind == 3) ei = 1'b1;
    ev = {kind != 0, es, et, em, ei, ep, ek};
    av = {sq_valid[t], sq_seq[t*SEQ_W +: SEQ_W], sq_target[t*PC_W +: PC_W],
          sq_mispc[t*PC_W +: PC_W], sq_incl[t], sq_mispred[t], sq_taken[t]};
    chk(req, $sformatf("thread %0d squash fields", t), 128'(av), 128'(ev));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    clear_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "strobes and flags",
        128'({sq_valid, sq_incl, sq_mispred, sq_taken, blk_handled}), 128'(0));
    chk("R1", "fields", 128'({sq_seq, sq_target}), 128'(0));
    chk("R1", "counters", 128'({cnt_tkn_wrong, cnt_ntk_wrong}), 128'(0));
    rst_n = 1'b1;
    step();

    // Table walk
    for (int vi = 0; vi < NV; vi++) begin
      logic [31:0] w;
      w = VECS[vi];
      clear_inputs();
      grp_valid = 1'b1;
      for (int i = 0; i < LANES; i++) begin
        logic [5:0] lw;
        logic [PC_W-1:0] pc;
        lw = w[8 + 6*i +: 6];
        pc = PC_W'(32'h4000 + vi*256 + i*4);
        b_valid[i] = lw[5];
        b_tid[i]   = TID_W'(lw[4]);
        b_mp[i]    = lw[3];
        b_mo[i]    = lw[2];
        b_lb[i]    = lw[1];
        b_seq[i]   = SEQ_W'(256 + vi*16 + i);
        b_pc[i]    = pc;
        b_npc[i]   = lw[0] ? pc + 32'h40 : pc + 32'd4;
      end
      step();
      exp_thread(0, int'(w[3:2]), int'(w[1:0]), vreq(vi));
      exp_thread(1, int'(w[7:6]), int'(w[5:4]), vreq(vi));
      chk("R7", $sformatf("handled after vector %0d", vi), 128'(blk_handled),
          128'({w[7:6] == 2'd3, w[3:2] == 2'd3}));
      idle_rearm();
    end
    chk("R9", "counts after table", 128'({cnt_tkn_wrong, cnt_ntk_wrong}),
        128'({CNT_W'(e_tkn), CNT_W'(e_ntk)}));

    // R10: group not valid, lanes carry events
    clear_inputs();
    set_lane(0, 0, 7, 32'h100, 32'h200, 1, 0, 0);
    set_lane(1, 1, 8, 32'h300, 32'h304, 0, 1, 0);
    step();
    chk("R10", "no squash without group valid", 128'(sq_valid), 128'(0));

    // R7/R8: blocked-load handling
    clear_inputs();
    grp_valid = 1'b1;
    set_lane(0, 0, 20, 32'h500, 32'h504, 0, 0, 1);
    step();
    exp_thread(0, 3, 0, "R7");
    chk("R7", "handled set", 128'(blk_handled), 128'(2'b01));
    clear_inputs();
    grp_valid = 1'b1;
    set_lane(0, 0, 21, 32'h510, 32'h514, 0, 0, 1);
    set_lane(1, 1, 22, 32'h520, 32'h524, 0, 0, 1);
    step();
    chk("R8", "thread0 blocked load ignored while handled", 128'(sq_valid[0]), 128'(0));
    exp_thread(1, 3, 1, "R8");
    chk("R8", "both handled", 128'(blk_handled), 128'(2'b11));
    clear_inputs();
    grp_valid = 1'b1;
    rearm = 2'b01;
    set_lane(0, 0, 23, 32'h530, 32'h534, 0, 0, 1);
    step();
    chk("R8", "rearm same cycle does not re-arm", 128'(sq_valid[0]), 128'(0));
    chk("R8", "rearm clears thread0 only", 128'(blk_handled), 128'(2'b10));
    clear_inputs();
    grp_valid = 1'b1;
    set_lane(2, 0, 24, 32'h540, 32'h544, 0, 0, 1);
    step();
    exp_thread(0, 3, 2, "R8");
    idle_rearm();
    chk("R8", "idle rearm clears all", 128'(blk_handled), 128'(0));
    clear_inputs();
    grp_valid = 1'b1;
    rearm = 2'b10;
    set_lane(0, 1, 25, 32'h550, 32'h554, 0, 0, 1);
    step();
    exp_thread(1, 3, 0, "R8");
    chk("R8", "set wins over rearm", 128'(blk_handled[1]), 128'(1));
    idle_rearm();

    // R5: taken boundary with INST_BYTES = 4
    clear_inputs();
    grp_valid = 1'b1;
    set_lane(0, 0, 30, 32'h100, 32'h104, 1, 0, 0);
    step();
    chk("R5", "npc = pc+4 not taken", 128'(sq_taken[0]), 128'(0));
    exp_thread(0, 1, 0, "R4");
    clear_inputs();
    grp_valid = 1'b1;
    set_lane(0, 0, 31, 32'h100, 32'h108, 1, 0, 0);
    step();
    chk("R5", "npc = pc+8 taken", 128'(sq_taken[0]), 128'(1));
    exp_thread(0, 1, 0, "R4");
    clear_inputs();
    grp_valid = 1'b1;
    set_lane(3, 1, 32, 32'h100, 32'h100, 1, 0, 0);
    step();
    chk("R5", "npc = pc taken", 128'(sq_taken[1]), 128'(1));
    exp_thread(1, 1, 3, "R4");
    clear_inputs();
    grp_valid = 1'b1;
    set_lane(1, 1, 33, 32'h700, 32'h7f0, 0, 1, 0);
    step();
    chk("R6", "memorder taken and mispredict low",
        128'({sq_taken[1], sq_mispred[1], sq_incl[1]}), 128'(0));
    exp_thread(1, 2, 1, "R6");
    clear_inputs();
    step();
    chk("R9", "final counts", 128'({cnt_tkn_wrong, cnt_ntk_wrong}),
        128'({CNT_W'(e_tkn), CNT_W'(e_ntk)}));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule